// File: doc/BRIEF.md
# Highway and Side-Road Signal Controller

This block sequences the lamps at a crossing where a busy highway meets a lightly used side road. The highway keeps the right of way until something asks for it. A car on the side-road sensor, or a pedestrian who wants to cross the highway, can take the green away from the highway, but only once the highway has been green for a guaranteed minimum time. The side road then gets a green phase. That phase has a floor, and it is extended while cars keep arriving, up to a fixed ceiling. Each hand-over between the roads passes through a yellow phase of fixed length.

All timing is counted in pulses of a one-cycle tick enable, nominally one per second, which is generated outside the block. Three internal interval timers measure the long, medium and short periods. Each timer is cleared by a trigger and then holds a done flag once its period has elapsed. The periods are parameters (`LONG_TICKS`, `MID_TICKS`, `SHORT_TICKS`, with defaults of 60, 30 and 10). The pedestrian input is assumed to be debounced already.

Top module: `tlc_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, the highway lamps are green, the side lamps are red and walk is low.
- R2: While there is no pending demand (no car sensed and no latched pedestrian request), the highway stays green indefinitely.
- R3: Highway green moves to highway yellow only once demand is present and at least `LONG_TICKS` ticks have been counted since the highway turned green. Ticks that arrive in the cycle the phase is entered are not counted.
- R4: A yellow phase on either road lasts until `SHORT_TICKS` ticks have been counted since it began. The phase ends in the cycle after the last of those ticks.
- R5: When the highway yellow ends, the highway shows red and the side road shows green in the same cycle.
- R6: Side green lasts at least `MID_TICKS` ticks. After that it ends in the first cycle in which the car sensor is low. It ends unconditionally once `LONG_TICKS` ticks have been counted since the side road turned green.
- R7: When the side yellow ends, the side road shows red and the highway shows green in the same cycle.
- R8: Each lamp output is one-hot, with bit 2 = red, bit 1 = yellow and bit 0 = green. At most one road is non-red at any time.
- R9: A pedestrian request is latched and counts as demand. Walk is high only while a request is latched and the highway is red. The latch clears when the highway turns green, unless a new request arrives in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick_i | input | 1 | One-cycle time-base enable, one pulse per second |
| car_i | input | 1 | Side-road car sensor |
| walk_req_i | input | 1 | Debounced pedestrian request to cross the highway |
| hwy_lamps_o | output | 3 | Highway lamps {red, yellow, green}, one-hot |
| side_lamps_o | output | 3 | Side-road lamps {red, yellow, green}, one-hot |
| walk_o | output | 1 | Walk indication for crossing the highway |

## Verification
A wrong phase register is visible on the lamp outputs in the very next sampled cycle, because the lamps decode the phase directly. A miscounting timer or a wrong done flag moves a phase boundary by whole ticks. The bench catches this at the first boundary where the design and the model disagree. A pedestrian latch that clears at the wrong moment shows up on walk_o as soon as the highway turns red, or as an early end to highway green once the minimum has passed. The traffic patterns used exercise:
- the side-green floor
- the demand extension
- the ceiling
- the drop of the sensor part-way through the extension

// File: rtl/tlc_pkg.sv
package tlc_pkg;

  typedef enum logic [1:0] {
    PH_HWY_GO    = 2'd0,
    PH_HWY_SLOW  = 2'd1,
    PH_SIDE_GO   = 2'd2,
    PH_SIDE_SLOW = 2'd3
  } phase_e;

  localparam int LAMP_W = 3;
  typedef logic [LAMP_W-1:0] lamp_t;

  localparam lamp_t LAMP_RED = 3'b100;
  localparam lamp_t LAMP_YEL = 3'b010;
  localparam lamp_t LAMP_GRN = 3'b001;

  function automatic lamp_t hwy_lamp(phase_e ph);
    case (ph)
      PH_HWY_GO:   return LAMP_GRN;
      PH_HWY_SLOW: return LAMP_YEL;
      default:     return LAMP_RED;
    endcase
  endfunction

  function automatic lamp_t side_lamp(phase_e ph);
    case (ph)
      PH_SIDE_GO:   return LAMP_GRN;
      PH_SIDE_SLOW: return LAMP_YEL;
      default:      return LAMP_RED;
    endcase
  endfunction

endpackage

// File: rtl/tlc_interval_timer.sv
module tlc_interval_timer #(
  parameter int unsigned PERIOD = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic trig_i,
  output logic done_o
);
  localparam int unsigned CW = (PERIOD < 2) ? 1 : $clog2(PERIOD);
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;

  always_comb begin
    cnt_d  = cnt_q;
    done_d = done_q;
    if (trig_i) begin
      cnt_d  = '0;
      done_d = 1'b0;
    end else if (tick_i && !done_q) begin
      if (cnt_q == LAST) begin
        done_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign done_o = done_q;

  // Timing for R4 and R6: a trigger always clears the flag
  assert_trig_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trig_i |=> !done_o);

  // The flag is sticky until the next trigger (R4, R6)
  assert_done_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !trig_i) |=> done_o);

  // The flag can only rise on a tick (R4)
  assert_done_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(tick_i));

endmodule

// File: rtl/tlc_demand_latch.sv
module tlc_demand_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  logic pend_q, pend_d;

  always_comb begin
    pend_d = pend_q;
    if (clr_i) pend_d = 1'b0;
    if (set_i) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  assert_req_latched_R9: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> pend_o);

  assert_clear_works_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !pend_o);

endmodule

// File: rtl/tlc_sequencer.sv
module tlc_sequencer
  import tlc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   car_i,
  input  logic   ped_pend_i,
  input  logic   long_done_i,
  input  logic   mid_done_i,
  input  logic   short_done_i,
  output phase_e phase_o,
  output logic   long_trig_o,
  output logic   mid_trig_o,
  output logic   short_trig_o,
  output logic   ped_clr_o
);
  phase_e phase_q, phase_d;
  logic   demand;

  assign demand = car_i | ped_pend_i;

  always_comb begin
    phase_d      = phase_q;
    long_trig_o  = 1'b0;
    mid_trig_o   = 1'b0;
    short_trig_o = 1'b0;
    ped_clr_o    = 1'b0;
    case (phase_q)
      PH_HWY_GO: begin
        if (long_done_i && demand) begin
          phase_d      = PH_HWY_SLOW;
          short_trig_o = 1'b1;
        end
      end
      PH_HWY_SLOW: begin
        if (short_done_i) begin
          phase_d     = PH_SIDE_GO;
          mid_trig_o  = 1'b1;
          long_trig_o = 1'b1;
        end
      end
      PH_SIDE_GO: begin
        if (long_done_i || (mid_done_i && !car_i)) begin
          phase_d      = PH_SIDE_SLOW;
          short_trig_o = 1'b1;
        end
      end
      default: begin
        if (short_done_i) begin
          phase_d     = PH_HWY_GO;
          long_trig_o = 1'b1;
          ped_clr_o   = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_HWY_GO;
    else        phase_q <= phase_d;
  end

  assign phase_o = phase_q;

  // Side green is entered only from highway yellow
  assert_side_from_yellow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_SIDE_GO && $past(phase_q) != PH_SIDE_GO) |-> $past(phase_q) == PH_HWY_SLOW);

  // Highway green is re-entered only from side yellow
  assert_hwy_from_yellow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_HWY_GO && $past(phase_q) != PH_HWY_GO) |-> $past(phase_q) == PH_SIDE_SLOW);

endmodule

// File: rtl/tlc_ctrl.sv
module tlc_ctrl
  import tlc_pkg::*;
#(
  parameter int unsigned LONG_TICKS  = 60,
  parameter int unsigned MID_TICKS   = 30,
  parameter int unsigned SHORT_TICKS = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       car_i,
  input  logic       walk_req_i,
  output logic [2:0] hwy_lamps_o,
  output logic [2:0] side_lamps_o,
  output logic       walk_o
);
  localparam int unsigned NTMR = 3;
  localparam int unsigned PERIODS [NTMR] = '{LONG_TICKS, MID_TICKS, SHORT_TICKS};

  phase_e          phase;
  logic [NTMR-1:0] trig, done;
  logic            ped_pend, ped_clr;

  for (genvar g = 0; g < NTMR; g++) begin : g_tmr
    tlc_interval_timer #(.PERIOD(PERIODS[g])) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (tick_i),
      .trig_i (trig[g]),
      .done_o (done[g])
    );
  end

  tlc_demand_latch u_ped (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (walk_req_i),
    .clr_i  (ped_clr),
    .pend_o (ped_pend)
  );

  tlc_sequencer u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .car_i        (car_i),
    .ped_pend_i   (ped_pend),
    .long_done_i  (done[0]),
    .mid_done_i   (done[1]),
    .short_done_i (done[2]),
    .phase_o      (phase),
    .long_trig_o  (trig[0]),
    .mid_trig_o   (trig[1]),
    .short_trig_o (trig[2]),
    .ped_clr_o    (ped_clr)
  );

  assign hwy_lamps_o  = hwy_lamp(phase);
  assign side_lamps_o = side_lamp(phase);
  assign walk_o       = ped_pend & hwy_lamps_o[2];

  assert_lamps_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(hwy_lamps_o) && $onehot(side_lamps_o));

  assert_one_road_moving_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hwy_lamps_o[2] || side_lamps_o[2]);

  assert_walk_on_red_R9: assert property (@(posedge clk) disable iff (!rst_n)
    walk_o |-> hwy_lamps_o[2]);

  assert_hwy_min_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hwy_lamps_o[0]) |-> $past(done[0]));

  assert_side_floor_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(side_lamps_o[0]) |-> $past(done[1]));

endmodule

// File: tb/sim_tlc_ctrl.sv
module sim_tlc_ctrl;
  localparam int L = 6;
  localparam int M = 3;
  localparam int S = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic car = 1'b0;
  logic req = 1'b0;
  logic [2:0] hwy, side;
  logic walk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int tick_every = 4;
  int tick_cnt = 0;
  int walk_seen = 0;

  // model state
  int m_ph = 0;
  int m_el = 0;
  bit m_pend = 0;

  always #2.5 clk = ~clk;

  tlc_ctrl #(.LONG_TICKS(L), .MID_TICKS(M), .SHORT_TICKS(S)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .car_i(car), .walk_req_i(req),
    .hwy_lamps_o(hwy), .side_lamps_o(side), .walk_o(walk)
  );

  function automatic logic [2:0] exp_hwy(int ph);
    return (ph == 0) ? 3'b001 : (ph == 1) ? 3'b010 : 3'b100;
  endfunction
  function automatic logic [2:0] exp_side(int ph);
    return (ph == 2) ? 3'b001 : (ph == 3) ? 3'b010 : 3'b100;
  endfunction

  task automatic check(string tag, logic [2:0] act, logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d actual %b expected %b", tag, cyc, act, exp);
    end
  endtask

  // reference model: phase and ticks counted since phase entry
  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_el = 0; m_pend = 0;
    end else begin
      bit go = 0;
      bit newpend = m_pend;
      case (m_ph)
        0: go = (m_el >= L) && (car || m_pend);
        1: go = (m_el >= S);
        2: go = (m_el >= L) || ((m_el >= M) && !car);
        default: go = (m_el >= S);
      endcase
      if (go && m_ph == 3) newpend = 0;
      if (req) newpend = 1;
      if (go) begin
        m_ph = (m_ph + 1) % 4;
        m_el = 0;
      end else if (tick) begin
        m_el++;
      end
      m_pend = newpend;
    end
  end

  // comparison on every cycle, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      string tg;
      tg = (m_ph == 0) ? "R2/R3" : (m_ph == 1) ? "R4/R5" : (m_ph == 2) ? "R6" : "R4/R7";
      check({tg, " hwy"}, hwy, exp_hwy(m_ph));
      check({tg, " side"}, side, exp_side(m_ph));
      check("R9 walk", {2'b0, walk}, {2'b0, m_pend && (m_ph >= 2)});
      checks++;
      if (!($onehot(hwy) && $onehot(side) && (hwy[2] || side[2]))) begin
        errors++;
        $display("FAIL R8 cycle %0d actual hwy %b side %b expected one-hot with one red", cyc, hwy, side);
      end
      if (walk) walk_seen++;
    end
    tick_cnt++;
    tick = (tick_cnt % tick_every) == 0;
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  // watchdog
  initial begin
    run(150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    run(3);
    check("R1 hwy in reset", hwy, 3'b001);
    check("R1 side in reset", side, 3'b100);
    check("R1 walk in reset", {2'b0, walk}, 3'b000);
    rst_n = 1'b1;
    run(1);
    check("R1 hwy after release", hwy, 3'b001);
    // R2: no demand, long run
    run(200);
    check("R2 hwy still green", hwy, 3'b001);
    // R3..R6: car held through side ceiling
    car = 1; run(150);
    // R6: floor only
    car = 0; run(100);
    car = 1;
    while (side != 3'b001) run(1);
    car = 0; run(100);
    // R6: drop during extension
    car = 1;
    while (side != 3'b001) run(1);
    run(4 * M + 6);
    car = 0; run(100);
    // R9: pedestrian only
    req = 1; run(1); req = 0;
    run(150);
    check("R9 walk observed", {2'b0, walk_seen > 0}, 3'b001);
    // R9: request while highway green minimum still running
    while (hwy != 3'b100) begin car = 1; run(1); end
    car = 0;
    while (hwy != 3'b001) run(1);
    req = 1; run(1); req = 0; run(150);
    // fast ticks, toggling sensor
    tick_every = 1;
    for (int i = 0; i < 40; i++) begin
      car = (i % 3) != 0;
      run(7);
    end
    car = 0; run(80);
    // reset in mid-cycle then R1 again
    car = 1; run(30);
    rst_n = 0; run(2);
    check("R1 hwy re-reset", hwy, 3'b001);
    check("R1 side re-reset", side, 3'b100);
    rst_n = 1; car = 0; run(20);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule